// File: doc/BRIEF.md
# LCD AC-Drive Phase Toggle Generator

This block produces the alternating polarity level (the "M" or AC-drive signal) that a passive-matrix flat panel needs so its liquid crystal never sees a net DC voltage. The level flips either on frame boundaries or after a programmed number of horizontal-sync pulses. Frame and line pulses come from the panel timing logic. A flag from that logic reports whether frame acceleration is active. Under acceleration every CRT frame maps onto two panel frames, so the frame-based source then flips only on every second frame pulse.

Software reaches one 8-bit control register through a two-port indexed scheme. It first writes the register number to the index port, then reads or writes the data port. The control register sits at index 1Eh. Bit 7 picks frame-based toggling when set. Bits 6..0 hold a line count stored as the real number of sync pulses minus two. The line source applies only when bit 7 is clear and that stored count exceeds 2. Otherwise the block falls back to frame-based toggling, so the output never parks at a fixed level. Any write to the control register restarts the line and frame counters, and a new setting therefore always starts from a clean count. The output is driven only in flat-panel mode and is held low otherwise.

Top module: `lcd_acdrive_top`

## Requirements
- R1: After reset the index register and the control register read 00h and `m_out` is low.
- R2: A write with `reg_port`=0 loads the index register, and a read with `reg_port`=0 returns it. With the index at 1Eh, a write with `reg_port`=1 loads the control register, and a read with `reg_port`=1 returns the last value written.
- R3: A data-port write while the index is not 1Eh changes no state: the control register keeps its value and a data-port read at such an index returns 00h.
- R4: With control bit 7 = 1 and `frame_accel` low, `m_out` inverts on the clock edge that samples each `frame_pulse`, and `hsync_pulse` has no effect on it.
- R5: With control bit 7 = 1 and `frame_accel` high, `m_out` inverts only on every second `frame_pulse`, counted from the last control write.
- R6: With control bit 7 = 0 and bits 6..0 = N with N > 2, `m_out` inverts on the edge that samples the (N+2)-th `hsync_pulse`, and `frame_pulse` has no effect on it.
- R7: With control bit 7 = 0 and N <= 2, the block behaves as in R4/R5 (frame-based toggling that follows `frame_accel`), and `hsync_pulse` has no effect.
- R8: The sync-pulse count restarts at zero on every line-based inversion, so inversions repeat every N+2 pulses.
- R9: A control-register write clears the sync-pulse count and the accelerated-frame parity, and any `hsync_pulse` or `frame_pulse` sampled in the same cycle as that write is discarded.
- R10: While `flat_en` is low, `m_out` is held low and both counters are held at zero. When `flat_en` rises again, counting starts afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle |
| reg_port | input | 1 | 0 selects the index port, 1 selects the data port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the port selected by `reg_port` |
| flat_en | input | 1 | Flat-panel mode active |
| frame_accel | input | 1 | Frame acceleration active |
| hsync_pulse | input | 1 | One-cycle horizontal-sync pulse |
| frame_pulse | input | 1 | One-cycle frame-start pulse |
| m_out | output | 1 | AC-drive phase level |

## Verification
A control-register write can land in the same clock cycle as the timing pulse that would otherwise complete a count. The write must win: the pulse is discarded and the count restarts. The bench provokes this in line mode by raising `hsync_pulse` together with a data-port write, two pulses short of the inversion. It then confirms that the inversion arrives only after a full N+2 new pulses. It repeats the test in accelerated frame mode by pairing a write with a `frame_pulse` while the parity sits at its half-way point, and confirms that two more frames are needed before the level flips.

// File: rtl/lcd_acd_pkg.sv
package lcd_acd_pkg;

  localparam int DATA_W = 8;
  localparam int CNT_W  = 7;

  // Control register layout: bit 7 selects frame toggling, bits 6..0 line count
  typedef struct packed {
    logic             frame_sel;
    logic [CNT_W-1:0] line_cnt;
  } acd_ctrl_t;

  typedef enum logic {
    PORT_INDEX = 1'b0,
    PORT_DATA  = 1'b1
  } acd_port_e;

endpackage

// File: rtl/acd_regfile.sv
module acd_regfile
  import lcd_acd_pkg::*;
#(
  parameter logic [DATA_W-1:0] CTRL_INDEX = 8'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_port,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output acd_ctrl_t         ctrl,
  output logic              ctrl_wr
);

  logic [DATA_W-1:0] index_q, index_d;
  acd_ctrl_t         ctrl_q, ctrl_d;
  logic              index_en, ctrl_en, ctrl_hit;

  assign ctrl_hit = (index_q == CTRL_INDEX);
  assign index_en = reg_we && (reg_port == PORT_INDEX);
  assign ctrl_en  = reg_we && (reg_port == PORT_DATA) && ctrl_hit;

  always_comb begin
    index_d = index_q;
    ctrl_d  = ctrl_q;
    if (index_en) index_d = reg_wdata;
    if (ctrl_en)  ctrl_d  = acd_ctrl_t'(reg_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;
      ctrl_q  <= '0;
    end else begin
      index_q <= index_d;
      ctrl_q  <= ctrl_d;
    end
  end

  always_comb begin
    if (reg_port == PORT_INDEX) reg_rdata = index_q;
    else if (ctrl_hit)          reg_rdata = ctrl_q;
    else                        reg_rdata = '0;
  end

  assign ctrl    = ctrl_q;
  assign ctrl_wr = ctrl_en;

  // R3: control only moves on a data-port write at the control index
  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_port && (index_q == CTRL_INDEX)) |=> $stable(ctrl_q));

endmodule

// File: rtl/acd_line_counter.sv
module acd_line_counter #(
  parameter int HS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            clear,
  input  logic            hsync,
  input  logic [HS_W-1:0] last,
  output logic            tick
);

  logic [HS_W-1:0] hs_cnt_q, hs_cnt_d;
  logic            cnt_en;

  always_comb begin
    hs_cnt_d = hs_cnt_q;
    tick     = 1'b0;
    cnt_en   = 1'b1;
    if (clear || !enable) begin
      hs_cnt_d = '0;
    end else if (hsync) begin
      if (hs_cnt_q == last) begin
        hs_cnt_d = '0;
        tick     = 1'b1;
      end else begin
        hs_cnt_d = hs_cnt_q + 1'b1;
      end
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hs_cnt_q <= '0;
    else if (cnt_en) hs_cnt_q <= hs_cnt_d;
  end

  // R6: the running count never passes the programmed terminal value
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !clear) |-> (hs_cnt_q <= last));

  // R9: a control write leaves the count at zero
  p_wr_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (hs_cnt_q == '0));

  // R10: disabled counter stays idle
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (hs_cnt_q == '0));

endmodule

// File: rtl/acd_frame_divider.sv
module acd_frame_divider (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic clear,
  input  logic accel,
  input  logic frame_pulse,
  output logic tick
);

  logic parity_q, parity_d;

  always_comb begin
    parity_d = parity_q;
    tick     = 1'b0;
    if (clear || !enable) begin
      parity_d = 1'b0;
    end else if (!accel) begin
      parity_d = 1'b0;
      tick     = frame_pulse;
    end else if (frame_pulse) begin
      tick     = parity_q;
      parity_d = !parity_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) parity_q <= 1'b0;
    else        parity_q <= parity_d;
  end

  // R5: under acceleration two consecutive frame pulses never both tick
  p_accel_halves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && accel) |=> !parity_q);

  // R9: write clears the half-rate parity
  p_parity_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !parity_q);

endmodule

// File: rtl/lcd_acdrive_top.sv
module lcd_acdrive_top
  import lcd_acd_pkg::*;
#(
  parameter logic [DATA_W-1:0] CTRL_INDEX  = 8'h1E,
  parameter int                LINE_OFFSET = 2,
  parameter int                MIN_PROG    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_port,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              flat_en,
  input  logic              frame_accel,
  input  logic              hsync_pulse,
  input  logic              frame_pulse,
  output logic              m_out
);

  localparam int HS_W = CNT_W + 1;
  localparam logic [HS_W-1:0] LAST_ADJ = HS_W'(LINE_OFFSET - 1);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_PROG);

  acd_ctrl_t       ctrl;
  logic            ctrl_wr;
  logic            line_mode;
  logic [HS_W-1:0] line_last;
  logic            line_tick, frame_tick;
  logic            m_q, m_d;

  acd_regfile #(.CTRL_INDEX(CTRL_INDEX)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_port  (reg_port),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ctrl      (ctrl),
    .ctrl_wr   (ctrl_wr)
  );

  assign line_mode = !ctrl.frame_sel && (ctrl.line_cnt > MIN_CNT);
  assign line_last = {1'b0, ctrl.line_cnt} + LAST_ADJ;

  acd_line_counter #(.HS_W(HS_W)) u_lines (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (flat_en && line_mode),
    .clear  (ctrl_wr),
    .hsync  (hsync_pulse),
    .last   (line_last),
    .tick   (line_tick)
  );

  acd_frame_divider u_frames (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (flat_en && !line_mode),
    .clear       (ctrl_wr),
    .accel       (frame_accel),
    .frame_pulse (frame_pulse),
    .tick        (frame_tick)
  );

  always_comb begin
    if (!flat_en) m_d = 1'b0;
    else          m_d = m_q ^ (line_tick | frame_tick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_q <= 1'b0;
    else        m_q <= m_d;
  end

  assign m_out = m_q;

  // R10: output is low in the cycle after flat-panel mode is off
  p_low_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flat_en |=> !m_out);

  // R4: no pulse, no phase change
  p_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flat_en && !hsync_pulse && !frame_pulse) |=> (m_out == $past(m_out)));

  // R4: frame mode without acceleration inverts on each frame pulse
  p_frame_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flat_en && ctrl.frame_sel && !frame_accel && frame_pulse && !ctrl_wr)
      |=> (m_out != $past(m_out)));

  // R9: a control write never coincides with a phase change
  p_wr_no_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flat_en && ctrl_wr) |=> (m_out == $past(m_out)));

endmodule

// File: tb/test_lcd_acdrive_top.sv
module test_lcd_acdrive_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we, reg_port;
  logic [7:0] reg_wdata, reg_rdata;
  logic       flat_en, frame_accel, hsync_pulse, frame_pulse;
  logic       m_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  lcd_acdrive_top i_lcd_acdrive_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_port(reg_port),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flat_en(flat_en),
    .frame_accel(frame_accel), .hsync_pulse(hsync_pulse),
    .frame_pulse(frame_pulse), .m_out(m_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic port, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_port = port; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic port, output logic [7:0] d);
    @(negedge clk);
    reg_port = port;
    #1 d = reg_rdata;
  endtask

  task automatic set_ctrl(logic [7:0] d);
    wr(1'b0, 8'h1E);
    wr(1'b1, d);
  endtask

  task automatic hs(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); hsync_pulse = 1'b1;
      @(negedge clk); hsync_pulse = 1'b0;
    end
  endtask

  task automatic fr(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_pulse = 1'b1;
      @(negedge clk); frame_pulse = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(1'b0, d); check("R1 index after reset", d, 8'h00);
    check("R1 m_out after reset", {7'b0, m_out}, 8'h00);
    wr(1'b0, 8'h1E);
    rd(1'b1, d); check("R1 ctrl after reset", d, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(1'b0, 8'h1E);
    rd(1'b0, d); check("R2 index readback", d, 8'h1E);
    wr(1'b1, 8'hA5);
    rd(1'b1, d); check("R2 ctrl readback", d, 8'hA5);
  endtask

  task automatic t_ignore;
    logic [7:0] d;
    wr(1'b0, 8'h1D);
    wr(1'b1, 8'h3C);
    rd(1'b1, d); check("R3 other index reads zero", d, 8'h00);
    wr(1'b0, 8'h1E);
    rd(1'b1, d); check("R3 ctrl untouched", d, 8'hA5);
  endtask

  task automatic t_frame;
    logic m0;
    frame_accel = 1'b0;
    set_ctrl(8'h80);
    m0 = m_out;
    hs(3); check("R4 hsync ignored", {7'b0, m_out}, {7'b0, m0});
    fr(1); check("R4 first frame flip", {7'b0, m_out}, {7'b0, !m0});
    fr(1); check("R4 second frame flip", {7'b0, m_out}, {7'b0, m0});
  endtask

  task automatic t_accel;
    logic m0;
    frame_accel = 1'b1;
    set_ctrl(8'h80);
    m0 = m_out;
    fr(1); check("R5 accel odd frame hold", {7'b0, m_out}, {7'b0, m0});
    fr(1); check("R5 accel even frame flip", {7'b0, m_out}, {7'b0, !m0});
    fr(1); check("R5 accel odd frame hold 2", {7'b0, m_out}, {7'b0, !m0});
    fr(1); check("R5 accel even frame flip 2", {7'b0, m_out}, {7'b0, m0});
    frame_accel = 1'b0;
  endtask

  task automatic t_line;
    logic m0;
    set_ctrl(8'h03);   // N=3 -> 5 sync pulses
    m0 = m_out;
    fr(2); check("R6 frame ignored in line mode", {7'b0, m_out}, {7'b0, m0});
    hs(4); check("R6 four pulses hold", {7'b0, m_out}, {7'b0, m0});
    hs(1); check("R6 fifth pulse flips", {7'b0, m_out}, {7'b0, !m0});
    hs(4); check("R8 restart hold", {7'b0, m_out}, {7'b0, !m0});
    hs(1); check("R8 restart flips", {7'b0, m_out}, {7'b0, m0});
  endtask

  task automatic t_fallback;
    logic m0;
    set_ctrl(8'h02);
    m0 = m_out;
    hs(6); check("R7 count 2 ignores hsync", {7'b0, m_out}, {7'b0, m0});
    fr(1); check("R7 count 2 frame flip", {7'b0, m_out}, {7'b0, !m0});
    frame_accel = 1'b1;
    set_ctrl(8'h00);
    m0 = m_out;
    fr(1); check("R7 fallback accel hold", {7'b0, m_out}, {7'b0, m0});
    fr(1); check("R7 fallback accel flip", {7'b0, m_out}, {7'b0, !m0});
    frame_accel = 1'b0;
  endtask

  task automatic t_collide;
    logic m0;
    set_ctrl(8'h03);
    m0 = m_out;
    hs(3);
    @(negedge clk);
    reg_we = 1'b1; reg_port = 1'b1; reg_wdata = 8'h03; hsync_pulse = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; hsync_pulse = 1'b0;
    check("R9 write with hsync no flip", {7'b0, m_out}, {7'b0, m0});
    hs(4); check("R9 count restarted hold", {7'b0, m_out}, {7'b0, m0});
    hs(1); check("R9 count restarted flip", {7'b0, m_out}, {7'b0, !m0});
    frame_accel = 1'b1;
    set_ctrl(8'h80);
    m0 = m_out;
    fr(1);
    @(negedge clk);
    reg_we = 1'b1; reg_port = 1'b1; reg_wdata = 8'h80; frame_pulse = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; frame_pulse = 1'b0;
    check("R9 write with frame no flip", {7'b0, m_out}, {7'b0, m0});
    fr(1); check("R9 parity cleared hold", {7'b0, m_out}, {7'b0, m0});
    fr(1); check("R9 parity cleared flip", {7'b0, m_out}, {7'b0, !m0});
    frame_accel = 1'b0;
  endtask

  task automatic t_flat;
    set_ctrl(8'h80);
    if (m_out == 1'b0) fr(1);
    check("R10 setup high", {7'b0, m_out}, 8'h01);
    @(negedge clk); flat_en = 1'b0;
    @(negedge clk);
    check("R10 low when off", {7'b0, m_out}, 8'h00);
    fr(2); check("R10 frames ignored when off", {7'b0, m_out}, 8'h00);
    flat_en = 1'b1;
    set_ctrl(8'h03);
    hs(3);
    @(negedge clk); flat_en = 1'b0;
    @(negedge clk); flat_en = 1'b1;
    hs(4); check("R10 count cleared hold", {7'b0, m_out}, 8'h00);
    hs(1); check("R10 count cleared flip", {7'b0, m_out}, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_port = 1'b0; reg_wdata = '0;
    flat_en = 1'b0; frame_accel = 1'b0; hsync_pulse = 1'b0; frame_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_ignore();
    flat_en = 1'b1;
    t_frame();
    t_accel();
    t_line();
    t_fallback();
    t_collide();
    t_flat();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule